// File: doc/BRIEF.md
# Watchdog Timer with Encoded Interval

This block is a watchdog whose timeout is set by a single 8-bit control byte on a small register bus. The byte packs a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout, counted in ticks of an external 1/16-second enable, is the multiplier times four raised to the resolution code. Software keeps the watchdog quiet by writing the control byte or by reading it. Either access restarts the count and clears the expiry flag.

When the count runs out, the block sets an expiry flag in a read-only status register. The steering bit then picks one of two actions. With the bit set, the block issues a one-cycle reset request, clears the control byte and clears the era bit of a companion register. With the bit clear, it issues a one-cycle interrupt pulse. Each expiry is one-shot, and the watchdog stays idle until the next access to the control byte. The system reset itself is generated outside this block.

Top module: `wdt_top`

## Requirements
- R1: After reset, `wdt_rst_req` and `wdt_irq` are 0, and reads of the status (offset 0), control (offset 1) and era (offset 2) registers all return 0x00. Read data appears on `bus_rdata` in the cycle after the read request.
- R2: The control byte sets the timeout as follows. The multiplier is bits 6:2 and the resolution code is bits 1:0. The expiry action takes effect at the clock edge that samples the Nth `tick_en` pulse after arming, where N = multiplier × 4^code. It takes effect no earlier than that edge.
- R3: A control byte of 0x00, or any byte whose multiplier is zero, leaves the watchdog disarmed, and it never expires.
- R4: A bus write to the control register stores the byte, clears the expiry flag and restarts the count using the new byte.
- R5: A bus read of the control register returns the stored byte, clears the expiry flag and restarts the count using the stored byte.
- R6: On expiry, status bit 7 becomes 1, and it stays 1 until the next control access. Bus writes to the status register have no effect.
- R7: If control bit 7 (the steering bit) is set at expiry, `wdt_rst_req` is high for exactly one cycle and `wdt_irq` stays low. In the same cycle the control byte becomes 0x00 and era bit 6 becomes 0.
- R8: If the steering bit is clear at expiry, `wdt_irq` is high for exactly one cycle, `wdt_rst_req` stays low and the control byte is unchanged. The watchdog does not expire again until the control byte is accessed.
- R9: A control access in the same cycle as a `tick_en` pulse takes priority: that tick neither counts nor causes an expiry.
- R10: The era register (offset 2) stores only bit 6 of a written byte. Its other bits read as 0.
- R11: Only clock cycles with `tick_en` high advance the count. Idle clock cycles do not advance it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 1/16-second time base enable, one cycle wide |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset (0 status, 1 control, 2 era) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wdt_rst_req | output | 1 | One-cycle reset request on steered expiry |
| wdt_irq | output | 1 | One-cycle interrupt on unsteered expiry |

## Verification
The bench counts ticks right up to each boundary. It checks that nothing fires one tick early and that the action fires exactly on the Nth tick. It covers the smallest interval, the mixed codes and the 1984-tick maximum, so a design that decodes the resolution code as a power of two, or that is off by one, would fire early or late. It checks that a zero multiplier with a nonzero code stays silent; a design that tested only for a zero byte would fire at once or wrap around. It checks that restart happens both on a read and on a write, and that a coincident tick loses to the access. It also checks that a steered expiry clears the control and era bits, which a design that stored the action but forgot the side effects would miss. Finally, it checks that an unsteered expiry does not fire again by itself.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int DATA_W = 8;
  parameter int MULT_W = 5;
  parameter int RES_W  = 2;
  localparam int NUM_RES = 1 << RES_W;
  localparam int CNT_W   = MULT_W + 2 * (NUM_RES - 1);
  localparam int FIELD_W = MULT_W + RES_W;

  localparam int STEER_BIT = 7;
  localparam int FLAG_BIT  = 7;
  localparam int ERA_BIT   = 6;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CTRL   = 2'd1,
    REG_ERA    = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdt_interval.sv
module wdt_interval
  import wdt_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  output logic [CNT_W-1:0]   ticks
);
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  logic [CNT_W-1:0]  scaled [NUM_RES];

  assign mult = field[FIELD_W-1:RES_W];
  assign res  = field[RES_W-1:0];

  // one shifted copy per resolution code, picked by the code
  for (genvar g = 0; g < NUM_RES; g++) begin : g_scale
    assign scaled[g] = CNT_W'(mult) << (2 * g);
  end

  assign ticks = scaled[res];
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             armed,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;

  // a load in the same cycle wins over a tick
  assign fire = armed && tick && !load && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= load_val;
      armed <= |load_val;
    end else if (armed && tick) begin
      if (cnt == CNT_W'(1)) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fire,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl,
  output logic              flag,
  output logic              kick
);
  logic era;
  logic hit_ctrl, hit_era, hit_stat;

  assign hit_ctrl = (addr == ADDR_W'(REG_CTRL));
  assign hit_era  = (addr == ADDR_W'(REG_ERA));
  assign hit_stat = (addr == ADDR_W'(REG_STATUS));
  assign kick     = sel && hit_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      flag  <= 1'b0;
      era   <= 1'b0;
      rdata <= '0;
    end else begin
      if (sel && wr && hit_ctrl) ctrl <= wdata;
      if (sel && wr && hit_era)  era  <= wdata[ERA_BIT];
      if (kick) flag <= 1'b0;
      if (fire) begin
        flag <= 1'b1;
        if (ctrl[STEER_BIT]) begin
          ctrl <= '0;
          era  <= 1'b0;
        end
      end
      if (sel && !wr) begin
        if (hit_stat)      rdata <= DATA_W'(flag) << FLAG_BIT;
        else if (hit_ctrl) rdata <= ctrl;
        else if (hit_era)  rdata <= DATA_W'(era) << ERA_BIT;
        else               rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              wdt_rst_req,
  output logic              wdt_irq
);
  logic [DATA_W-1:0] ctrl;
  logic [DATA_W-1:0] kick_val;
  logic [CNT_W-1:0]  interval;
  logic              flag, kick, armed, fire;

  wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .fire(fire), .rdata(bus_rdata), .ctrl(ctrl),
    .flag(flag), .kick(kick)
  );

  // a write arms from the new byte, a read from the stored one
  assign kick_val = bus_wr ? bus_wdata : ctrl;

  wdt_interval u_ival (
    .field(kick_val[FIELD_W-1:0]), .ticks(interval)
  );

  wdt_countdown u_cnt (
    .clk(clk), .rst(rst), .load(kick), .load_val(interval),
    .tick(tick_en), .armed(armed), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_rst_req <= 1'b0;
      wdt_irq     <= 1'b0;
    end else begin
      wdt_rst_req <= fire && ctrl[STEER_BIT];
      wdt_irq     <= fire && !ctrl[STEER_BIT];
    end
  end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_en,
  input logic       kick,
  input logic       armed,
  input logic       flag,
  input logic [7:0] ctrl,
  input logic       rst_req,
  input logic       irq
);
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && irq));
  p_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (rst_req || irq) |-> flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (ctrl == 8'h00));
  p_notick_r11: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> !(rst_req || irq));
  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!armed && !kick) |=> !(rst_req || irq));
  p_kick_r9: assert property (@(posedge clk) disable iff (rst)
    kick |=> !(rst_req || irq));
  p_kick_clr_r4: assert property (@(posedge clk) disable iff (rst)
    kick |=> !flag);
endmodule

bind wdt_top wdt_chk u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .kick(kick), .armed(armed),
  .flag(flag), .ctrl(ctrl), .rst_req(wdt_rst_req), .irq(wdt_irq)
);

// File: tb/tb_wdt_top.sv
`timescale 1ns/1ps
module tb_wdt_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wdt_rst_req, wdt_irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  wdt_top #(.ADDR_W(2)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
  );

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // n back-to-back ticks; reports any reset/irq seen from them
  task automatic run_ticks(input int n, output logic r, output logic i);
    r = 1'b0; i = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      r |= wdt_rst_req; i |= wdt_irq;
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
    r |= wdt_rst_req; i |= wdt_irq;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R1 rst_req", wdt_rst_req, 0);
    chk("R1 irq", wdt_irq, 0);
    rd_reg(2'd0, d); chk("R1 status", d, 8'h00);
    rd_reg(2'd2, d); chk("R1 era", d, 8'h00);
    rd_reg(2'd1, d); chk("R1 ctrl", d, 8'h00);
  endtask

  task automatic interval_case(input logic [7:0] c, input int n);
    logic r, i;
    wr_reg(2'd1, c);
    run_ticks(n - 1, r, i);
    chk("R2 no early fire", int'(r | i), 0);
    run_ticks(1, r, i);
    chk("R2 irq on Nth tick", i, 1);
    chk("R8 no reset request", r, 0);
    @(negedge clk);
    chk("R8 irq one cycle", wdt_irq, 0);
  endtask

  task automatic t_interval();
    interval_case(8'h0C, 3);
    interval_case(8'h05, 4);
    interval_case(8'h0A, 32);
    interval_case(8'h04, 1);
    interval_case(8'h7F, 1984);
  endtask

  task automatic t_gaps();
    logic r, i;
    wr_reg(2'd1, 8'h0C);
    for (int k = 0; k < 2; k++) begin
      run_ticks(1, r, i);
      repeat (10) @(negedge clk);
    end
    chk("R11 idle cycles do not count", int'(r | i | wdt_irq), 0);
    run_ticks(1, r, i);
    chk("R11 third tick fires", i, 1);
  endtask

  task automatic t_zero();
    logic r, i;
    logic [7:0] d;
    wr_reg(2'd1, 8'h00);
    run_ticks(40, r, i);
    chk("R3 zero byte silent", int'(r | i), 0);
    wr_reg(2'd1, 8'h03);
    run_ticks(40, r, i);
    chk("R3 zero multiplier silent", int'(r | i), 0);
    rd_reg(2'd0, d); chk("R3 no flag", d, 8'h00);
  endtask

  task automatic t_wr_restart();
    logic r, i;
    logic [7:0] d;
    wr_reg(2'd1, 8'h0C);
    run_ticks(3, r, i);
    rd_reg(2'd0, d); chk("R6 flag set", d, 8'h80);
    wr_reg(2'd1, 8'h0C);
    rd_reg(2'd0, d); chk("R4 write clears flag", d, 8'h00);
    run_ticks(2, r, i);
    wr_reg(2'd1, 8'h0C);
    run_ticks(2, r, i);
    chk("R4 write restarts", int'(r | i), 0);
    run_ticks(1, r, i);
    chk("R4 fires after restart", i, 1);
  endtask

  task automatic t_rd_restart();
    logic r, i;
    logic [7:0] d;
    rd_reg(2'd0, d); chk("R6 flag before read", d, 8'h80);
    rd_reg(2'd1, d); chk("R5 read returns ctrl", d, 8'h0C);
    rd_reg(2'd0, d); chk("R5 read clears flag", d, 8'h00);
    run_ticks(2, r, i);
    rd_reg(2'd1, d);
    run_ticks(2, r, i);
    chk("R5 read restarts", int'(r | i), 0);
    run_ticks(1, r, i);
    chk("R5 fires after read restart", i, 1);
  endtask

  task automatic t_one_shot();
    logic r, i;
    logic [7:0] d;
    run_ticks(20, r, i);
    chk("R8 no refire", int'(r | i), 0);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, d); chk("R6 status write ignored", d, 8'h80);
    rd_reg(2'd1, d); chk("R8 ctrl kept", d, 8'h0C);
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, d); chk("R6 status write ignored when clear", d, 8'h00);
  endtask

  task automatic t_steer();
    logic r, i;
    logic [7:0] d;
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd2, d); chk("R10 era only bit 6", d, 8'h40);
    wr_reg(2'd1, 8'h85);
    run_ticks(3, r, i);
    chk("R7 no early reset", int'(r | i), 0);
    run_ticks(1, r, i);
    chk("R7 reset request", r, 1);
    chk("R7 no irq", i, 0);
    @(negedge clk);
    chk("R7 reset one cycle", wdt_rst_req, 0);
    rd_reg(2'd0, d); chk("R7 flag set", d, 8'h80);
    rd_reg(2'd2, d); chk("R7 era cleared", d, 8'h00);
    rd_reg(2'd1, d); chk("R7 ctrl cleared", d, 8'h00);
  endtask

  task automatic t_coincide();
    logic r, i;
    wr_reg(2'd1, 8'h04);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1;
    bus_addr = 2'd1; bus_wdata = 8'h08;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R9 access beats tick", int'(wdt_irq | wdt_rst_req), 0);
    run_ticks(1, r, i);
    chk("R9 coincident tick not counted", int'(r | i), 0);
    run_ticks(1, r, i);
    chk("R9 fires on second tick", i, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_interval();
    t_gaps();
    t_zero();
    t_wr_restart();
    t_rd_restart();
    t_one_shot();
    t_steer();
    t_coincide();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule